// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the integer and single-precision register state of a 32-bit core. Sixteen integer registers are visible at any time. The lower eight are backed by two physical copies. Which copy is live depends on two bits of a status register that the block also holds: the privilege bit and the bank-select bit. The upper eight registers exist once and are the same whichever copy is live. Two combinational read ports and one clocked write port serve the visible integer registers.

The single-precision file is built from two physical groups of sixteen words. One bit of a floating-point control register, also held here, decides which group appears as the front view (indices 0 to 15) and which appears as the back view (indices 16 to 31). Changing either control register never moves or loses any data. It only changes which physical copy each index names.

A debug read port takes a signed absolute index. It returns either a visible integer register or a named physical copy of a banked register, whichever copy is live at the time. It raises an error flag for indices outside the legal window.

Top module: `banked_regfile`

## Requirements
- R1: On reset the status register reads 0x700000F0, which sets bit 30 (privilege) and bit 29 (bank select). The floating-point control register reads zero. Every integer and floating-point register reads zero.
- R2: Integer indices 0 to 7 select physical copy 1 only when status bits 30 and 29 are both 1. Any other combination of those two bits selects copy 0.
- R3: Integer indices 8 to 15 name a single shared set that does not depend on the status register.
- R4: A status write that changes the bank choice exchanges the live and hidden copies of indices 0 to 7. Values written before the change reappear when the earlier choice returns.
- R5: Read ports A and B return data combinationally and independently of each other. A read of the register being written in the same cycle returns the old value. The new value is visible after the clock edge.
- R6: Debug indices 0 to 15 return the visible integer registers. Indices 43 to 50 return physical copy 0 of registers 0 to 7. Indices 51 to 58 return physical copy 1. The physical copies are returned whichever copy is live.
- R7: A debug index below 0 or at 94 and above raises the error flag and returns zero data. The other indices in 16 to 93 that are not mapped return zero without the error flag.
- R8: Bit 21 of the floating-point control register selects the physical group shown at floating-point indices 0 to 15. Indices 16 to 31 show the other group. Toggling bit 21 exchanges the two views.
- R9: When a register write and a bank-changing control write happen in the same cycle, the register write lands in the copy that was live before the change. This applies to both the integer and the floating-point file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Integer register write enable |
| wr_idx | input | 4 | Integer write index |
| wr_data | input | 32 | Integer write data |
| sr_we | input | 1 | Status register write enable |
| sr_wdata | input | 32 | Status register write value |
| sr_q | output | 32 | Current status register |
| fpc_we | input | 1 | Floating-point control write enable |
| fpc_wdata | input | 32 | Floating-point control write value |
| fpc_q | output | 32 | Current floating-point control register |
| fp_rd_idx | input | 5 | Floating-point read index (16 and up = back view) |
| fp_rd_data | output | 32 | Floating-point read data |
| fp_we | input | 1 | Floating-point write enable |
| fp_wr_idx | input | 5 | Floating-point write index |
| fp_wr_data | input | 32 | Floating-point write data |
| dbg_idx | input | 8 | Signed debug absolute index |
| dbg_data | output | 32 | Debug read data |
| dbg_err | output | 1 | Debug index out of legal window |

## Verification
The bench builds the block with its default parameters: 32-bit words, sixteen integer registers of which eight are banked, sixteen words per floating-point group, and an 8-bit signed debug index. The 8-bit signed index reaches both edges of the legal window (-1, 0, 93, 94) and both extremes (-128, 127). Eight banked registers put both debug copy ranges and the unmapped gap between them within reach. All four combinations of the two status bits can be driven directly, so the bank-swap and same-cycle ordering cases are exercised on every banked index pattern used.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int          CTRL_W     = 32;
    localparam int          PRIV_POS   = 30;
    localparam int          BSEL_POS   = 29;
    localparam int          FPSEL_POS  = 21;
    localparam logic [31:0] STAT_RESET = 32'h7000_00F0;
    localparam logic [31:0] FPC_RESET  = 32'h0000_0000;

    // Debug window: copies of banked registers start at this absolute index.
    localparam int DBG_COPY_BASE = 43;
    localparam int DBG_LIMIT     = 94;

    typedef enum logic [2:0] {
        DK_VISIBLE,
        DK_COPY0,
        DK_COPY1,
        DK_UNMAPPED,
        DK_INVALID
    } dbg_kind_e;

    typedef struct packed {
        logic alt_gpr;
        logic alt_fpr;
    } bank_sel_t;

    function automatic dbg_kind_e dbg_classify(input int di, input int nreg, input int nbank);
        if (di < 0 || di >= DBG_LIMIT)                                  return DK_INVALID;
        if (di < nreg)                                                  return DK_VISIBLE;
        if (di >= DBG_COPY_BASE && di < DBG_COPY_BASE + nbank)          return DK_COPY0;
        if (di >= DBG_COPY_BASE + nbank && di < DBG_COPY_BASE + 2*nbank) return DK_COPY1;
        return DK_UNMAPPED;
    endfunction

endpackage

// File: rtl/brf_gpr_file.sv
module brf_gpr_file #(
    parameter int DW    = 32,
    parameter int NREG  = 16,
    parameter int NBANK = 8,
    parameter int NRD   = 3,
    localparam int IW   = $clog2(NREG),
    localparam int LW   = $clog2(NBANK),
    localparam int NSH  = NREG - NBANK,
    localparam int HW   = (NSH > 1) ? $clog2(NSH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alt,
    input  logic [NRD-1:0][IW-1:0]   rd_idx,
    output logic [NRD-1:0][DW-1:0]   rd_data,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     copy_sel,
    input  logic [LW-1:0]            copy_idx,
    output logic [DW-1:0]            copy_data
);

    logic [DW-1:0] lo_q [2][NBANK];
    logic [DW-1:0] hi_q [NSH];

    function automatic logic [HW-1:0] hi_off(input logic [IW-1:0] i);
        logic [IW-1:0] d;
        d = i - IW'(NBANK);
        return d[HW-1:0];
    endfunction

    function automatic logic [DW-1:0] vis_read(input logic [IW-1:0] i);
        if (i < IW'(NBANK)) return lo_q[alt][i[LW-1:0]];
        return hi_q[hi_off(i)];
    endfunction

    // Writes use the selection registered before this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < NBANK; k++)
                    lo_q[b][k] <= '0;
            for (int k = 0; k < NSH; k++)
                hi_q[k] <= '0;
        end else if (wr_en) begin
            if (wr_idx < IW'(NBANK)) lo_q[alt][wr_idx[LW-1:0]] <= wr_data;
            else                     hi_q[hi_off(wr_idx)]       <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = vis_read(rd_idx[p]);
    end

    assign copy_data = lo_q[copy_sel][copy_idx];

endmodule

// File: rtl/brf_fpr_file.sv
module brf_fpr_file #(
    parameter int DW  = 32,
    parameter int NFP = 16,
    localparam int FIW = $clog2(NFP)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           alt,
    input  logic [FIW:0]   rd_idx,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic [FIW:0]   wr_idx,
    input  logic [DW-1:0]  wr_data
);

    logic [DW-1:0] grp_q [2][NFP];

    // Front view is group 'alt', back view is the other group.
    logic rd_grp, wr_grp;
    assign rd_grp = alt ^ rd_idx[FIW];
    assign wr_grp = alt ^ wr_idx[FIW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < 2; g++)
                for (int k = 0; k < NFP; k++)
                    grp_q[g][k] <= '0;
        end else if (wr_en) begin
            grp_q[wr_grp][wr_idx[FIW-1:0]] <= wr_data;
        end
    end

    assign rd_data = grp_q[rd_grp][rd_idx[FIW-1:0]];

endmodule

// File: rtl/brf_dbg_decode.sv
module brf_dbg_decode
    import brf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DBG_W = 8,
    parameter int NREG  = 16,
    parameter int NBANK = 8,
    localparam int IW   = $clog2(NREG),
    localparam int LW   = $clog2(NBANK)
) (
    input  logic signed [DBG_W-1:0] dbg_idx,
    input  logic [DW-1:0]           vis_data,
    input  logic [DW-1:0]           copy_data,
    output logic [IW-1:0]           vis_idx,
    output logic                    copy_sel,
    output logic [LW-1:0]           copy_idx,
    output logic [DW-1:0]           dbg_data,
    output logic                    dbg_err
);

    int        di;
    dbg_kind_e kind;

    always_comb begin
        di       = int'(dbg_idx);
        kind     = dbg_classify(di, NREG, NBANK);
        vis_idx  = IW'(di);
        copy_sel = (kind == DK_COPY1);
        copy_idx = LW'(di - ((kind == DK_COPY1) ? (DBG_COPY_BASE + NBANK) : DBG_COPY_BASE));
        dbg_err  = (kind == DK_INVALID);
        unique case (kind)
            DK_VISIBLE:       dbg_data = vis_data;
            DK_COPY0, DK_COPY1: dbg_data = copy_data;
            default:          dbg_data = '0;
        endcase
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 16,
    parameter int NBANK = 8,
    parameter int NFP   = 16,
    parameter int DBG_W = 8,
    localparam int IW   = $clog2(NREG),
    localparam int LW   = $clog2(NBANK),
    localparam int FIW  = $clog2(NFP),
    localparam int NRD  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IW-1:0]            rd_a_idx,
    output logic [DW-1:0]            rd_a_data,
    input  logic [IW-1:0]            rd_b_idx,
    output logic [DW-1:0]            rd_b_data,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic                     sr_we,
    input  logic [CTRL_W-1:0]        sr_wdata,
    output logic [CTRL_W-1:0]        sr_q,
    input  logic                     fpc_we,
    input  logic [CTRL_W-1:0]        fpc_wdata,
    output logic [CTRL_W-1:0]        fpc_q,
    input  logic [FIW:0]             fp_rd_idx,
    output logic [DW-1:0]            fp_rd_data,
    input  logic                     fp_we,
    input  logic [FIW:0]             fp_wr_idx,
    input  logic [DW-1:0]            fp_wr_data,
    input  logic signed [DBG_W-1:0]  dbg_idx,
    output logic [DW-1:0]            dbg_data,
    output logic                     dbg_err
);

    bank_sel_t sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= STAT_RESET;
            fpc_q <= FPC_RESET;
        end else begin
            if (sr_we)  sr_q  <= sr_wdata;
            if (fpc_we) fpc_q <= fpc_wdata;
        end
    end

    assign sel.alt_gpr = sr_q[PRIV_POS] & sr_q[BSEL_POS];
    assign sel.alt_fpr = fpc_q[FPSEL_POS];

    logic [NRD-1:0][IW-1:0] gpr_rd_idx;
    logic [NRD-1:0][DW-1:0] gpr_rd_data;
    logic [IW-1:0]          dbg_vis_idx;
    logic                   dbg_copy_sel;
    logic [LW-1:0]          dbg_copy_idx;
    logic [DW-1:0]          dbg_copy_data;

    assign gpr_rd_idx = {dbg_vis_idx, rd_b_idx, rd_a_idx};
    assign rd_a_data  = gpr_rd_data[0];
    assign rd_b_data  = gpr_rd_data[1];

    brf_gpr_file #(.DW(DW), .NREG(NREG), .NBANK(NBANK), .NRD(NRD)) u_gpr (
        .clk       (clk),
        .rst       (rst),
        .alt       (sel.alt_gpr),
        .rd_idx    (gpr_rd_idx),
        .rd_data   (gpr_rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .copy_sel  (dbg_copy_sel),
        .copy_idx  (dbg_copy_idx),
        .copy_data (dbg_copy_data)
    );

    brf_fpr_file #(.DW(DW), .NFP(NFP)) u_fpr (
        .clk     (clk),
        .rst     (rst),
        .alt     (sel.alt_fpr),
        .rd_idx  (fp_rd_idx),
        .rd_data (fp_rd_data),
        .wr_en   (fp_we),
        .wr_idx  (fp_wr_idx),
        .wr_data (fp_wr_data)
    );

    brf_dbg_decode #(.DW(DW), .DBG_W(DBG_W), .NREG(NREG), .NBANK(NBANK)) u_dbg (
        .dbg_idx   (dbg_idx),
        .vis_data  (gpr_rd_data[2]),
        .copy_data (dbg_copy_data),
        .vis_idx   (dbg_vis_idx),
        .copy_sel  (dbg_copy_sel),
        .copy_idx  (dbg_copy_idx),
        .dbg_data  (dbg_data),
        .dbg_err   (dbg_err)
    );

endmodule

// File: rtl/brf_chk.sv
module brf_chk
    import brf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 16,
    parameter int NBANK = 8,
    localparam int IW   = $clog2(NREG)
) (
    input logic                clk,
    input logic                rst,
    input logic [IW-1:0]       rd_a_idx,
    input logic [DW-1:0]       rd_a_data,
    input logic                wr_en,
    input logic [IW-1:0]       wr_idx,
    input logic [DW-1:0]       wr_data,
    input logic [CTRL_W-1:0]   sr_q,
    input logic [DW-1:0]       dbg_data,
    input logic                dbg_err
);

    logic live_alt;
    assign live_alt = sr_q[PRIV_POS] & sr_q[BSEL_POS];

    a_r1_reset_status: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sr_q == STAT_RESET);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_a_data == '0);

    a_r5_write_then_read: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && rd_a_idx == $past(wr_idx) && live_alt == $past(live_alt))
        |-> rd_a_data == $past(wr_data));

    a_r3_shared_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && $stable(rd_a_idx) && rd_a_idx >= IW'(NBANK))
        |-> $stable(rd_a_data));

    a_r7_err_zero: assert property (@(posedge clk) disable iff (rst)
        dbg_err |-> dbg_data == '0);

endmodule

bind banked_regfile brf_chk #(.DW(DW), .NREG(NREG), .NBANK(NBANK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sr_q      (sr_q),
    .dbg_data  (dbg_data),
    .dbg_err   (dbg_err)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

    logic              clk = 0;
    logic              rst = 1;
    logic [3:0]        rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
    logic [31:0]       rd_a_data, rd_b_data, wr_data = 0;
    logic              wr_en = 0, sr_we = 0, fpc_we = 0, fp_we = 0;
    logic [31:0]       sr_wdata = 0, sr_q, fpc_wdata = 0, fpc_q;
    logic [4:0]        fp_rd_idx = 0, fp_wr_idx = 0;
    logic [31:0]       fp_rd_data, fp_wr_data = 0;
    logic signed [7:0] dbg_idx = 0;
    logic [31:0]       dbg_data;
    logic              dbg_err;

    always #5 clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_q(sr_q),
        .fpc_we(fpc_we), .fpc_wdata(fpc_wdata), .fpc_q(fpc_q),
        .fp_rd_idx(fp_rd_idx), .fp_rd_data(fp_rd_data),
        .fp_we(fp_we), .fp_wr_idx(fp_wr_idx), .fp_wr_data(fp_wr_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .dbg_err(dbg_err)
    );

    // Reference state derived from the requirements.
    logic [31:0] m_lo [2][8];
    logic [31:0] m_hi [8];
    logic [31:0] m_fp [2][16];
    logic [31:0] m_sr  = 32'h7000_00F0;
    logic [31:0] m_fpc = 32'h0;

    typedef struct { string tag; int src; logic [31:0] exp; } item_t;
    item_t sb[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    function automatic logic [31:0] gexp(input logic [3:0] i);
        logic a;
        a = m_sr[30] & m_sr[29];
        if (i < 4'd8) return m_lo[a][i[2:0]];
        return m_hi[3'(i - 4'd8)];
    endfunction

    function automatic logic [31:0] fexp(input logic [4:0] i);
        logic g;
        g = m_fpc[21] ^ i[4];
        return m_fp[g][i[3:0]];
    endfunction

    task automatic push(input string tag, input int src, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.src = src; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic clock_in();
        logic a, g;
        logic [2:0] k;
        a = m_sr[30] & m_sr[29];
        if (wr_en) begin
            k = wr_idx[2:0];
            if (wr_idx < 4'd8) m_lo[a][k] = wr_data;
            else m_hi[3'(wr_idx - 4'd8)] = wr_data;
        end
        if (fp_we) begin
            g = m_fpc[21] ^ fp_wr_idx[4];
            m_fp[g][fp_wr_idx[3:0]] = fp_wr_data;
        end
        if (sr_we)  m_sr  = sr_wdata;
        if (fpc_we) m_fpc = fpc_wdata;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; sr_we = 0; fpc_we = 0; fp_we = 0;
    endtask

    task automatic wr_gpr(input logic [3:0] i, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1; wr_idx = i; wr_data = v;
        clock_in();
    endtask

    task automatic wr_sr(input logic [31:0] v);
        @(negedge clk);
        sr_we = 1; sr_wdata = v;
        clock_in();
    endtask

    task automatic chk_a(input logic [3:0] i, input string tag);
        @(negedge clk);
        rd_a_idx = i;
        push(tag, 0, gexp(i));
    endtask

    task automatic chk_pair(input logic [3:0] ia, input logic [3:0] ib, input string tag);
        @(negedge clk);
        rd_a_idx = ia; rd_b_idx = ib;
        push(tag, 0, gexp(ia));
        push(tag, 1, gexp(ib));
    endtask

    task automatic chk_fp(input logic [4:0] i, input string tag);
        @(negedge clk);
        fp_rd_idx = i;
        push(tag, 2, fexp(i));
    endtask

    task automatic chk_dbg(input logic signed [7:0] d, input string tag);
        int di;
        logic [31:0] e;
        logic err;
        di = int'(d);
        err = (di < 0) || (di >= 94);
        e = 32'h0;
        if (!err) begin
            if (di < 16) e = gexp(4'(di));
            else if (di >= 43 && di < 51) e = m_lo[0][3'(di - 43)];
            else if (di >= 51 && di < 59) e = m_lo[1][3'(di - 51)];
        end
        @(negedge clk);
        dbg_idx = d;
        push(tag, 3, e);
        push(tag, 4, {31'b0, err});
    endtask

    task automatic chk_ctrl(input string tag);
        @(negedge clk);
        push(tag, 5, m_sr);
        push(tag, 6, m_fpc);
    endtask

    // Monitor: compare queued expectations mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.src)
                    0: act = rd_a_data;
                    1: act = rd_b_data;
                    2: act = fp_rd_data;
                    3: act = dbg_data;
                    4: act = {31'b0, dbg_err};
                    5: act = sr_q;
                    default: act = fpc_q;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s (src %0d): got %h expected %h", it.tag, it.src, act, it.exp);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int k = 0; k < 8; k++) m_lo[b][k] = 0;
        for (int k = 0; k < 8; k++) m_hi[k] = 0;
        for (int b = 0; b < 2; b++) for (int k = 0; k < 16; k++) m_fp[b][k] = 0;

        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        chk_ctrl("R1 control reset");
        chk_pair(4'd0, 4'd15, "R1 gpr reset");
        chk_fp(5'd0, "R1 fp front reset");
        chk_fp(5'd31, "R1 fp back reset");

        // Fill: bank 1 live after reset
        for (int i = 0; i < 8; i++) wr_gpr(4'(i), 32'hA0 + i);
        for (int i = 8; i < 16; i++) wr_gpr(4'(i), 32'h800 + i);
        chk_a(4'd3, "R2 copy1 live with both bits");
        chk_dbg(8'sd54, "R6 copy1 index");
        chk_dbg(8'sd46, "R6 copy0 index");
        chk_dbg(8'sd3, "R6 visible index");

        // R2/R4: privilege only -> copy 0
        wr_sr(32'h4000_0000);
        chk_a(4'd3, "R2 priv only selects copy0");
        chk_a(4'd10, "R3 shared after swap");
        wr_gpr(4'd3, 32'hB3);
        wr_sr(32'h2000_0000);
        chk_a(4'd3, "R2 bank bit only selects copy0");
        wr_sr(32'h6000_0000);
        chk_a(4'd3, "R4 earlier copy returns");
        chk_dbg(8'sd46, "R6 copy0 while copy1 live");
        chk_dbg(8'sd54, "R6 copy1 while live");
        chk_ctrl("R4 status readback");

        // R5: read during write returns old value
        @(negedge clk);
        rd_a_idx = 4'd5; wr_en = 1; wr_idx = 4'd5; wr_data = 32'h55;
        push("R5 read-during-write old", 0, gexp(4'd5));
        clock_in();
        chk_a(4'd5, "R5 new value after edge");
        chk_pair(4'd5, 4'd12, "R5 two ports");

        // R9: write and swap in one cycle
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd2; wr_data = 32'hC2;
        sr_we = 1; sr_wdata = 32'h4000_0000;
        clock_in();
        chk_a(4'd2, "R9 write not in new copy");
        chk_dbg(8'sd53, "R9 write landed in old copy");
        chk_dbg(8'sd45, "R9 copy0 untouched");

        // R7: debug window edges
        chk_dbg(-8'sd1, "R7 below window");
        chk_dbg(8'sd94, "R7 at limit");
        chk_dbg(8'sd93, "R7 last legal");
        chk_dbg(8'sd20, "R7 unmapped gap");
        chk_dbg(8'sd127, "R7 max index");
        chk_dbg(-8'sd128, "R7 min index");
        chk_dbg(8'sd58, "R6 last copy1");
        chk_dbg(8'sd43, "R6 first copy0");

        // R8: floating-point views
        @(negedge clk); fp_we = 1; fp_wr_idx = 5'd0;  fp_wr_data = 32'h3F80_0000; clock_in();
        @(negedge clk); fp_we = 1; fp_wr_idx = 5'd16; fp_wr_data = 32'h4000_0000; clock_in();
        chk_fp(5'd0, "R8 front view");
        chk_fp(5'd16, "R8 back view");
        @(negedge clk); fpc_we = 1; fpc_wdata = 32'h0020_0000; clock_in();
        chk_fp(5'd0, "R8 front after toggle");
        chk_fp(5'd16, "R8 back after toggle");
        chk_ctrl("R8 control readback");

        // R9: fp write with toggle in same cycle
        @(negedge clk);
        fp_we = 1; fp_wr_idx = 5'd1; fp_wr_data = 32'h11;
        fpc_we = 1; fpc_wdata = 32'h0;
        clock_in();
        chk_fp(5'd1, "R9 fp front after toggle");
        chk_fp(5'd17, "R9 fp write in old group");

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule